// File: doc/BRIEF.md
# Binned Sample Statistics Tracker

This unit gathers running statistics on a stream of 8-bit converter codes. Each time the sample strobe is high, the code is counted into one of sixteen bins, and the running minimum, running maximum and most recent value are refreshed at the same clock edge. The bin is selected by the upper nibble of the code. Each bin count stops at its largest value rather than wrapping, so a long capture cannot corrupt the histogram.

A sequencer that sits outside this block drives the strobe and decides when a capture run begins. At the start of each run it pulses the run-clear input, which resets the three trackers and leaves the bins alone. Emptying the histogram is a separate request. Bin counts are read through an indexed port with one registered cycle of latency. The extremes and the last value are available as plain outputs.

Every cycle, an enumerated operation decoder chooses one of five operations: `OP_IDLE`, `OP_SAMPLE`, `OP_HIST_CLR`, `OP_RUN_CLR` and `OP_BOTH_CLR`. The clear operations take precedence over a sample. No state is carried from one cycle's operation to the next.

Top module: `stat_tracker`

## Requirements
- R1: There are 16 bins. A sample with code c is counted in bin c[7:4]. Index k on `rd_idx` reads bin k, for k = 0 to 15.
- R2: Each bin is an 8-bit counter. A count at 255 stays at 255 on further hits and never wraps to 0.
- R3: An accepted sample (strobe high, no clear in that cycle) updates its bin, `min_val`, `max_val` and `last_val` at the same clock edge, and `last_val` becomes the sample code.
- R4: `min_val` and `max_val` are the smallest and largest codes among the samples accepted since the latest run clear or reset.
- R5: A histogram clear sets all 16 bins to 0 at the next edge and leaves the min, max and last values unchanged.
- R6: Reset and a run clear both set `min_val`=0xFF, `max_val`=0x00 and `last_val`=0x00, so the first sample after them sets all three. A run clear leaves the bins unchanged, and reset zeroes them.
- R7: When the strobe is high in the same cycle as a histogram clear or a run clear, the sample is dropped: no bin counts it and no tracker takes it. Both clears together apply both effects.
- R8: `rd_bin` is registered. In the cycle after an edge, it shows the count of bin `rd_idx` as that count stood before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Sample strobe |
| sample_code | input | 8 | Converter code to record |
| hist_clr | input | 1 | Zero all bins |
| run_clr | input | 1 | Start a new run; reset the min, max and last trackers |
| rd_idx | input | 4 | Bin index for the read port |
| rd_bin | output | 8 | Registered count of the selected bin |
| min_val | output | 8 | Smallest code in the current run |
| max_val | output | 8 | Largest code in the current run |
| last_val | output | 8 | Most recent accepted code |

## Verification
A sample strobe can arrive in the same cycle as a histogram clear or a run clear. The bench provokes this by raising the strobe together with each clear, using codes that would visibly change a bin or a tracker if they were taken. It then judges the result through the read port and the tracker outputs: the bins must be zero after a histogram clear, and the trackers must hold their values, or show their run-start values after a run clear. The scoreboard also drives the saturation boundary past 255 hits in a single bin, and it confirms that a run clear keeps the counts already collected.

// File: rtl/stat_pkg.sv
package stat_pkg;
    // Per-cycle operation chosen by the top-level decoder; clears win over samples
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SAMPLE,
        OP_HIST_CLR,
        OP_RUN_CLR,
        OP_BOTH_CLR
    } stat_op_e;
endpackage

// File: rtl/stat_bin_counter.sv
module stat_bin_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/stat_extreme_track.sv
module stat_extreme_track #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              upd,
    input  logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] min_val,
    output logic [DATA_W-1:0] max_val,
    output logic [DATA_W-1:0] last_val
);
    localparam logic [DATA_W-1:0] CODE_TOP = '1;
    localparam logic [DATA_W-1:0] CODE_BOT = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_val  <= CODE_TOP;
            max_val  <= CODE_BOT;
            last_val <= CODE_BOT;
        end else if (init) begin
            min_val  <= CODE_TOP;
            max_val  <= CODE_BOT;
            last_val <= CODE_BOT;
        end else if (upd) begin
            last_val <= code;
            if (code < min_val) min_val <= code;
            if (code > max_val) max_val <= code;
        end
    end
endmodule

// File: rtl/stat_tracker.sv
module stat_tracker
    import stat_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample_code,
    input  logic              hist_clr,
    input  logic              run_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_bin,
    output logic [DATA_W-1:0] min_val,
    output logic [DATA_W-1:0] max_val,
    output logic [DATA_W-1:0] last_val
);
    localparam int NBINS = 1 << IDX_W;

    stat_op_e          op;
    logic              bins_zero;
    logic              trk_init;
    logic              take;
    logic [IDX_W-1:0]  sel;
    logic [CNT_W-1:0]  bin_cnt [NBINS];
    logic [NBINS*CNT_W-1:0] bin_cnt_flat;

    // Operation select: clears outrank the sample strobe
    always_comb begin
        if (hist_clr && run_clr) op = OP_BOTH_CLR;
        else if (run_clr)        op = OP_RUN_CLR;
        else if (hist_clr)       op = OP_HIST_CLR;
        else if (sample_vld)     op = OP_SAMPLE;
        else                     op = OP_IDLE;
    end

    // Controls for the operation chosen this cycle
    always_comb begin
        bins_zero = 1'b0;
        trk_init  = 1'b0;
        take      = 1'b0;
        unique case (op)
            OP_IDLE:     ;
            OP_SAMPLE:   take = 1'b1;
            OP_HIST_CLR: bins_zero = 1'b1;
            OP_RUN_CLR:  trk_init = 1'b1;
            OP_BOTH_CLR: begin
                bins_zero = 1'b1;
                trk_init  = 1'b1;
            end
            default: ;
        endcase
    end

    assign sel = sample_code[DATA_W-1 -: IDX_W];

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        logic hit;
        assign hit = take && (sel == IDX_W'(g));
        stat_bin_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (bins_zero),
            .inc  (hit),
            .cnt  (bin_cnt[g])
        );
        assign bin_cnt_flat[g*CNT_W +: CNT_W] = bin_cnt[g];
    end

    stat_extreme_track #(.DATA_W(DATA_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (trk_init),
        .upd     (take),
        .code    (sample_code),
        .min_val (min_val),
        .max_val (max_val),
        .last_val(last_val)
    );

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_bin <= '0;
        else        rd_bin <= bin_cnt[rd_idx];
    end
endmodule

// File: rtl/stat_tracker_chk.sv
module stat_tracker_chk #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sample_vld,
    input logic [DATA_W-1:0]        sample_code,
    input logic                     hist_clr,
    input logic                     run_clr,
    input logic [DATA_W-1:0]        min_val,
    input logic [DATA_W-1:0]        max_val,
    input logic [DATA_W-1:0]        last_val,
    input logic [(1<<IDX_W)*CNT_W-1:0] bin_cnt_flat
);
    localparam int NBINS = 1 << IDX_W;
    localparam logic [DATA_W-1:0] CODE_TOP = '1;

    AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !hist_clr && !run_clr) |=> (last_val == $past(sample_code))); // R3

    AST_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !hist_clr && !run_clr) |=> (min_val <= last_val && last_val <= max_val)); // R4

    AST_MIN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_clr |=> (min_val <= $past(min_val))); // R4

    AST_MAX_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !run_clr |=> (max_val >= $past(max_val))); // R4

    AST_RUN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_clr |=> (min_val == CODE_TOP && max_val == '0 && last_val == '0)); // R6

    AST_HIST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hist_clr |=> (bin_cnt_flat == '0)); // R5

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_clr && !run_clr) |=> ($stable(last_val) && $stable(min_val) && $stable(max_val))); // R7

    for (genvar g = 0; g < NBINS; g++) begin : g_chk
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            !hist_clr |=> (bin_cnt_flat[g*CNT_W +: CNT_W] >= $past(bin_cnt_flat[g*CNT_W +: CNT_W]))); // R2
    end
endmodule

bind stat_tracker stat_tracker_chk #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .sample_code (sample_code),
    .hist_clr    (hist_clr),
    .run_clr     (run_clr),
    .min_val     (min_val),
    .max_val     (max_val),
    .last_val    (last_val),
    .bin_cnt_flat(bin_cnt_flat)
);

// File: tb/test_stat_tracker.sv
module test_stat_tracker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_vld = 1'b0;
    logic [7:0] sample_code = '0;
    logic       hist_clr = 1'b0;
    logic       run_clr = 1'b0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_bin;
    logic [7:0] min_val;
    logic [7:0] max_val;
    logic [7:0] last_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Reference model
    int m_bin [16];
    int m_min = 255;
    int m_max = 0;
    int m_last = 0;

    typedef struct {
        int    idx;
        int    exp;
        string req;
    } rd_item_t;
    rd_item_t sb_q [$];
    logic rd_req = 1'b0;
    logic rd_req_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_tracker i_stat_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .sample_code(sample_code),
        .hist_clr   (hist_clr),
        .run_clr    (run_clr),
        .rd_idx     (rd_idx),
        .rd_bin     (rd_bin),
        .min_val    (min_val),
        .max_val    (max_val),
        .last_val   (last_val)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus model update
    task automatic step(bit v, logic [7:0] c, bit hc, bit rc);
        @(negedge clk);
        rd_req      = 1'b0;
        sample_vld  = v;
        sample_code = c;
        hist_clr    = hc;
        run_clr     = rc;
        if (hc) foreach (m_bin[i]) m_bin[i] = 0;
        if (rc) begin
            m_min = 255; m_max = 0; m_last = 0;
        end
        if (v && !hc && !rc) begin
            if (m_bin[c[7:4]] < 255) m_bin[c[7:4]]++;
            m_last = c;
            if (c < m_min) m_min = c;
            if (c > m_max) m_max = c;
        end
    endtask

    task automatic check_trk(string req);
        @(negedge clk);
        rd_req = 1'b0; sample_vld = 1'b0; hist_clr = 1'b0; run_clr = 1'b0;
        chk({req, " min"},  int'(min_val),  m_min);
        chk({req, " max"},  int'(max_val),  m_max);
        chk({req, " last"}, int'(last_val), m_last);
    endtask

    // Driver for the read port: expected value goes to the scoreboard
    task automatic read_bin(int idx, string req);
        rd_item_t it;
        @(negedge clk);
        sample_vld = 1'b0; hist_clr = 1'b0; run_clr = 1'b0;
        rd_idx = idx[3:0];
        rd_req = 1'b1;
        it.idx = idx; it.exp = m_bin[idx]; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic flush_reads();
        @(negedge clk);
        rd_req = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    always @(posedge clk) rd_req_d <= rd_req;

    // Monitor: compares each registered read result
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_d && sb_q.size() != 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk($sformatf("%s bin%0d", it.req, it.idx), int'(rd_bin), it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        foreach (m_bin[i]) m_bin[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check_trk("R6 reset");
        for (int k = 0; k < 16; k++) read_bin(k, "R1 reset zero");
        flush_reads();

        // Basic binning by upper nibble and tracker updates
        step(0, 8'h00, 0, 1);
        step(1, 8'h37, 0, 0);
        step(1, 8'h3A, 0, 0);
        step(1, 8'hF0, 0, 0);
        step(1, 8'h05, 0, 0);
        check_trk("R3 R4 basic");
        read_bin(3, "R1 nibble");
        read_bin(15, "R1 top");
        read_bin(0, "R1 bottom");
        read_bin(10, "R1 untouched");
        flush_reads();

        // Saturation
        for (int n = 0; n < 300; n++) step(1, 8'h84, 0, 0);
        read_bin(8, "R2 saturate");
        flush_reads();
        step(1, 8'h8F, 0, 0);
        read_bin(8, "R2 stay");
        flush_reads();
        check_trk("R3 after sat");

        // Run clear keeps bins, restarts trackers
        step(0, 8'h00, 0, 1);
        check_trk("R6 run clear");
        read_bin(3, "R6 bins kept");
        flush_reads();
        step(1, 8'h90, 0, 0);
        check_trk("R4 first sample");
        step(1, 8'h60, 0, 0);
        step(1, 8'hC1, 0, 0);
        step(1, 8'h70, 0, 0);
        check_trk("R4 run extremes");

        // Histogram clear with a sample in the same cycle
        step(1, 8'h11, 1, 0);
        check_trk("R7 hist clr trackers");
        for (int k = 0; k < 16; k++) read_bin(k, "R5 R7 hist clr");
        flush_reads();

        // Run clear with a sample in the same cycle
        step(1, 8'h22, 0, 0);
        step(1, 8'hE7, 0, 1);
        check_trk("R7 run clr trackers");
        read_bin(2, "R7 earlier count");
        read_bin(14, "R7 dropped");
        flush_reads();

        // Both clears together, with a sample
        step(1, 8'h5A, 0, 0);
        step(1, 8'h5B, 1, 1);
        check_trk("R7 both");
        read_bin(5, "R7 both");
        flush_reads();

        // Plain histogram clear leaves trackers
        step(1, 8'hA3, 0, 0);
        step(1, 8'h44, 0, 0);
        step(0, 8'h00, 1, 0);
        check_trk("R5 trackers kept");
        read_bin(10, "R5 zero");
        read_bin(4, "R5 zero");
        flush_reads();

        // Read port latency: sample lands in the same cycle as the read
        step(1, 8'h66, 0, 0);
        @(negedge clk);
        sample_vld = 1'b1; sample_code = 8'h67; rd_idx = 4'd6;
        hist_clr = 1'b0; run_clr = 1'b0;
        @(negedge clk);
        sample_vld = 1'b0;
        chk("R8 pre-edge value", int'(rd_bin), 1);
        @(negedge clk);
        chk("R8 next cycle", int'(rd_bin), 2);

        finish_run();
    end
endmodule